// File: doc/BRIEF.md
# Processor Bus Command Generator

This block sits between a processor's three encoded bus status lines and the command strobes of a memory and I/O bus. It watches for the status to leave the passive code and captures the code at that clock edge. It then runs a short sequence that drives the matching active-low strobe: memory read, memory write, I/O read, I/O write or interrupt acknowledge. Reads, interrupt acknowledge and the two advanced write strobes assert in the first cycle. The normal write strobes follow one cycle later, so that slow write targets get early notice.

Commands are gated by an active-low arbitration enable. A counter must see the enable held low for `GRANT_DELAY` clock edges before a gated command may start. A mode strap selects one of two bus modes. With the strap low (shared system bus), every command waits for the grant. With the strap high (dedicated I/O bus), I/O and interrupt-acknowledge commands start at once and ignore arbitration, while memory commands still wait. The strap also sets the meaning of a dual-purpose output. With the strap low it is an active-high cascade enable for interrupt acknowledge. With the strap high it is an active-low transceiver enable for I/O cycles. A direction output tells the transceiver which way data flows.

The controller has five named states. IDLE waits for a non-passive code. WAIT_GRANT holds a captured cycle until arbitration allows it. EARLY drives the first-phase strobes. FULL adds the normal write strobes. HALTED covers the halt code and drives nothing. The transitions are named as follows. Start goes from IDLE to EARLY when no grant is needed or the grant is present. Defer goes from IDLE to WAIT_GRANT when a needed grant is missing. Halt goes from IDLE to HALTED on code 011. Granted goes from WAIT_GRANT to EARLY. Advance goes from EARLY to FULL. Revoke goes from EARLY or FULL to WAIT_GRANT when a gated cycle sees the enable high. Finish goes from any state back to IDLE when the status is passive.

Top module: `bus_cmd_gen`

## Requirements
- R1: The status code captured at cycle start selects the strobe. 000 selects interrupt acknowledge. 001 selects I/O read. 010 selects I/O write (advanced and normal). 100 and 101 select memory read. 110 selects memory write (advanced and normal). 011 (halt) and 111 (passive) select no strobe.
- R2: All seven command strobes are active low. No more than one command kind is active at any time.
- R3: Read, interrupt acknowledge and advanced write strobes go low on the first rising edge after the capturing edge. The normal write strobe goes low one edge later.
- R4: The code is captured only at the edge where the status leaves 111. A later change to another non-passive code has no effect on the strobes. Every strobe returns high on the edge that samples 111.
- R5: With the strap low, no command starts until arbitration enable has been sampled low on GRANT_DELAY consecutive edges (default 2). The strobe goes low on the edge after that.
- R6: With the strap high, codes 000, 001 and 010 assert their strobes on the first edge regardless of arbitration enable. Memory codes still wait as in R5.
- R7: If a gated command sees arbitration enable high at an edge, its strobes go high at that edge, and the command waits for a fresh grant. Commands that are not gated are unaffected.
- R8: With the strap low, the dual-purpose output is high exactly while the interrupt-acknowledge strobe is active, and low otherwise.
- R9: With the strap high, the dual-purpose output is low exactly while an I/O read, I/O write or interrupt-acknowledge strobe is active, and high otherwise.
- R10: The direction output is high during write cycles (010, 110) and low for reads, interrupt acknowledge, halt and idle.
- R11: The halt code enters a state that drives no strobe until the status returns to passive.
- R12: While reset is asserted and after its release, every strobe is high, the direction output is low and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 3 | Encoded processor bus status, 111 is passive |
| arb_en_n_i | input | 1 | Active-low arbitration enable |
| io_bus_mode_i | input | 1 | Mode strap, 1 selects dedicated I/O bus mode |
| mem_rd_n_o | output | 1 | Memory read strobe, active low |
| mem_wr_n_o | output | 1 | Memory write strobe, active low |
| mem_wr_adv_n_o | output | 1 | Advanced memory write strobe, active low |
| io_rd_n_o | output | 1 | I/O read strobe, active low |
| io_wr_n_o | output | 1 | I/O write strobe, active low |
| io_wr_adv_n_o | output | 1 | Advanced I/O write strobe, active low |
| int_ack_n_o | output | 1 | Interrupt acknowledge strobe, active low |
| dual_en_o | output | 1 | Cascade enable (strap low, active high) or I/O transceiver enable (strap high, active low) |
| dir_o | output | 1 | Data direction, 1 for write |

## Verification
The assertions assume that the mode strap changes only while reset is asserted. They also assume that the status input is a clean synchronous signal that changes only between clock edges. The bench changes the strap only inside reset and drives every input half a period away from the rising edge. The assertions relating a strobe to an earlier arbitration sample assume the enable is itself synchronous. The bench therefore toggles it only at those same mid-cycle points.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam logic [2:0] STATUS_PASSIVE = 3'b111;

    typedef enum logic [2:0] {
        K_NONE,
        K_ACK,
        K_IORD,
        K_IOWR,
        K_MEMRD,
        K_MEMWR
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_GRANT,
        ST_EARLY,
        ST_FULL,
        ST_HALTED
    } state_e;

    function automatic kind_e decode_status(input logic [2:0] code);
        kind_e k;
        case (code)
            3'b000:  k = K_ACK;
            3'b001:  k = K_IORD;
            3'b010:  k = K_IOWR;
            3'b100:  k = K_MEMRD;
            3'b101:  k = K_MEMRD;
            3'b110:  k = K_MEMWR;
            default: k = K_NONE;
        endcase
        return k;
    endfunction

    // Memory cycles always wait for arbitration; I/O-side cycles only on the shared bus.
    function automatic logic needs_grant(input kind_e k, input logic io_mode);
        return (k == K_MEMRD) || (k == K_MEMWR) || !io_mode;
    endfunction

endpackage

// File: rtl/bcg_arb_timer.sv
module bcg_arb_timer #(
    parameter int GRANT_DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arb_en_n_i,
    output logic granted_o
);
    localparam int CW = $clog2(GRANT_DELAY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(GRANT_DELAY);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arb_en_n_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign granted_o = (cnt_q == LIMIT);

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    a_r5_grant_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        granted_o |-> $past(!arb_en_n_i));

endmodule

// File: rtl/bcg_sequencer.sv
module bcg_sequencer
    import bcg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic [2:0] status_i,
    input  logic   arb_en_n_i,
    input  logic   granted_i,
    input  logic   io_bus_mode_i,
    output state_e state_o,
    output kind_e  kind_o
);
    state_e state_q, state_d;
    kind_e  kind_q, kind_d;
    kind_e  new_kind;
    logic   passive;
    logic   gated_now;

    assign passive   = (status_i == STATUS_PASSIVE);
    assign new_kind  = decode_status(status_i);
    assign gated_now = needs_grant(kind_q, io_bus_mode_i);

    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!passive) begin
                    kind_d = new_kind;
                    if (new_kind == K_NONE)
                        state_d = ST_HALTED;                           // halt
                    else if (needs_grant(new_kind, io_bus_mode_i) && !granted_i)
                        state_d = ST_WAIT_GRANT;                       // defer
                    else
                        state_d = ST_EARLY;                            // start
                end
            end
            ST_WAIT_GRANT: begin
                if (passive)        state_d = ST_IDLE;                 // finish
                else if (granted_i) state_d = ST_EARLY;                // granted
            end
            ST_EARLY: begin
                if (passive)                       state_d = ST_IDLE;
                else if (gated_now && arb_en_n_i)  state_d = ST_WAIT_GRANT;  // revoke
                else                               state_d = ST_FULL;        // advance
            end
            ST_FULL: begin
                if (passive)                       state_d = ST_IDLE;
                else if (gated_now && arb_en_n_i)  state_d = ST_WAIT_GRANT;
            end
            ST_HALTED: begin
                if (passive) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (state_d == ST_IDLE) kind_d = K_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_NONE;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
        end
    end

    assign state_o = state_q;
    assign kind_o  = kind_q;

    a_r5_active_has_grant: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_EARLY || state_q == ST_FULL) && gated_now) |-> $past(!arb_en_n_i));

    a_r6_io_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && io_bus_mode_i &&
         (status_i == 3'b000 || status_i == 3'b001 || status_i == 3'b010)) |=> (state_q == ST_EARLY));

    a_r4_kind_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !passive) |=> (kind_q == $past(kind_q)));

endmodule

// File: rtl/bcg_strobe_out.sv
module bcg_strobe_out
    import bcg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_e state_i,
    input  kind_e  kind_i,
    input  logic   io_bus_mode_i,
    output logic   mem_rd_n_o,
    output logic   mem_wr_n_o,
    output logic   mem_wr_adv_n_o,
    output logic   io_rd_n_o,
    output logic   io_wr_n_o,
    output logic   io_wr_adv_n_o,
    output logic   int_ack_n_o,
    output logic   dual_en_o,
    output logic   dir_o
);
    logic phase1, phase2, io_side, holding;

    always_comb begin
        phase1  = (state_i == ST_EARLY) || (state_i == ST_FULL);
        phase2  = (state_i == ST_FULL);
        holding = (state_i == ST_WAIT_GRANT) || phase1;
        io_side = (kind_i == K_ACK) || (kind_i == K_IORD) || (kind_i == K_IOWR);

        mem_rd_n_o     = !(phase1 && kind_i == K_MEMRD);
        mem_wr_adv_n_o = !(phase1 && kind_i == K_MEMWR);
        mem_wr_n_o     = !(phase2 && kind_i == K_MEMWR);
        io_rd_n_o      = !(phase1 && kind_i == K_IORD);
        io_wr_adv_n_o  = !(phase1 && kind_i == K_IOWR);
        io_wr_n_o      = !(phase2 && kind_i == K_IOWR);
        int_ack_n_o    = !(phase1 && kind_i == K_ACK);

        if (io_bus_mode_i) dual_en_o = !(phase1 && io_side);
        else               dual_en_o = phase1 && (kind_i == K_ACK);

        dir_o = holding && (kind_i == K_MEMWR || kind_i == K_IOWR);
    end

    a_r2_single_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!mem_rd_n_o, !mem_wr_adv_n_o, !io_rd_n_o, !io_wr_adv_n_o, !int_ack_n_o}));

    a_r10_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_adv_n_o || !io_wr_adv_n_o) |-> dir_o);

endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
    import bcg_pkg::*;
#(
    parameter int GRANT_DELAY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] status_i,
    input  logic       arb_en_n_i,
    input  logic       io_bus_mode_i,
    output logic       mem_rd_n_o,
    output logic       mem_wr_n_o,
    output logic       mem_wr_adv_n_o,
    output logic       io_rd_n_o,
    output logic       io_wr_n_o,
    output logic       io_wr_adv_n_o,
    output logic       int_ack_n_o,
    output logic       dual_en_o,
    output logic       dir_o
);
    logic   granted;
    state_e state;
    kind_e  kind;

    bcg_arb_timer #(.GRANT_DELAY(GRANT_DELAY)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .arb_en_n_i (arb_en_n_i),
        .granted_o  (granted)
    );

    bcg_sequencer u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .status_i      (status_i),
        .arb_en_n_i    (arb_en_n_i),
        .granted_i     (granted),
        .io_bus_mode_i (io_bus_mode_i),
        .state_o       (state),
        .kind_o        (kind)
    );

    bcg_strobe_out u_out (
        .clk            (clk),
        .rst_n          (rst_n),
        .state_i        (state),
        .kind_i         (kind),
        .io_bus_mode_i  (io_bus_mode_i),
        .mem_rd_n_o     (mem_rd_n_o),
        .mem_wr_n_o     (mem_wr_n_o),
        .mem_wr_adv_n_o (mem_wr_adv_n_o),
        .io_rd_n_o      (io_rd_n_o),
        .io_wr_n_o      (io_wr_n_o),
        .io_wr_adv_n_o  (io_wr_adv_n_o),
        .int_ack_n_o    (int_ack_n_o),
        .dual_en_o      (dual_en_o),
        .dir_o          (dir_o)
    );

    a_r3_mem_norm_needs_adv: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n_o |-> !mem_wr_adv_n_o);

    a_r3_mem_norm_late: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n_o) |-> $past(!mem_wr_adv_n_o));

    a_r3_io_norm_late: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_wr_n_o) |-> $past(!io_wr_adv_n_o));

    a_r4_passive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status_i == STATUS_PASSIVE) |->
            (mem_rd_n_o && mem_wr_n_o && mem_wr_adv_n_o && io_rd_n_o &&
             io_wr_n_o && io_wr_adv_n_o && int_ack_n_o));

    a_r8_cascade_only_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_bus_mode_i && dual_en_o) |-> !int_ack_n_o);

    a_r9_pdata_io_only: assert property (@(posedge clk) disable iff (!rst_n)
        (io_bus_mode_i && !dual_en_o) |-> (!io_rd_n_o || !io_wr_adv_n_o || !int_ack_n_o));

endmodule

// File: tb/bus_cmd_gen_tb.sv
module bus_cmd_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] status = 3'b111;
    logic       arb_n = 1'b1;
    logic       strap = 1'b0;
    logic mrd, mwr, mwa, ird, iwr, iwa, ack, dual, dir;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bus_cmd_gen #(.GRANT_DELAY(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .status_i(status), .arb_en_n_i(arb_n),
        .io_bus_mode_i(strap), .mem_rd_n_o(mrd), .mem_wr_n_o(mwr),
        .mem_wr_adv_n_o(mwa), .io_rd_n_o(ird), .io_wr_n_o(iwr),
        .io_wr_adv_n_o(iwa), .int_ack_n_o(ack), .dual_en_o(dual), .dir_o(dir)
    );

    function automatic logic [8:0] outs();
        return {mrd, mwr, mwa, ird, iwr, iwa, ack, dual, dir};
    endfunction

    // phase 0 = idle, 1 = first cycle, 2 = second and later cycles
    function automatic logic [8:0] expect_vec(input logic s, input int code, input int phase);
        logic act, rm, wm, ir, iw, ia;
        act = (phase != 0);
        rm = act && (code == 4 || code == 5);
        wm = act && (code == 6);
        ir = act && (code == 1);
        iw = act && (code == 2);
        ia = act && (code == 0);
        return {!rm, !(wm && phase == 2), !wm, !ir, !(iw && phase == 2), !iw, !ia,
                s ? !(ir || iw || ia) : ia, wm || iw};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic s);
        rst_n = 1'b0;
        strap = s;
        status = 3'b111;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R12 reset state
        #1;
        check("R12 in reset", outs(), expect_vec(1'b0, 7, 0));
        do_reset(1'b0);
        check("R12 after reset", outs(), expect_vec(1'b0, 7, 0));

        // R1 R3 R8 R9 R10 R11: full sweep of codes in both modes, grant held
        for (int s = 0; s < 2; s++) begin
            do_reset(s[0]);
            arb_n = 1'b0;
            step(); step(); step();
            for (int c = 0; c < 8; c++) begin
                status = c[2:0];
                step();
                check("R1 R3 first cycle", outs(), expect_vec(s[0], c, (c == 3 || c == 7) ? 0 : 1));
                step();
                check("R3 R10 second cycle", outs(), expect_vec(s[0], c, (c == 3 || c == 7) ? 0 : 2));
                status = 3'b111;
                step();
                check("R4 R11 back to idle", outs(), expect_vec(s[0], c, 0));
            end
        end

        // R5 R7: shared bus, arbitration delay and revocation
        do_reset(1'b0);
        arb_n = 1'b1;
        status = 3'b101;
        step(); step(); step();
        check("R5 no grant", outs(), expect_vec(1'b0, 5, 0));
        arb_n = 1'b0;
        step();
        check("R5 one low sample", outs(), expect_vec(1'b0, 5, 0));
        step();
        check("R5 two low samples", outs(), expect_vec(1'b0, 5, 0));
        step();
        check("R5 strobe after delay", outs(), expect_vec(1'b0, 5, 1));
        step();
        arb_n = 1'b1;
        step();
        check("R7 revoked", outs(), expect_vec(1'b0, 5, 0));
        status = 3'b111;
        step();
        // R5 shared bus I/O also waits
        status = 3'b001;
        step();
        check("R5 io waits in shared mode", outs(), expect_vec(1'b0, 1, 0));
        status = 3'b111;
        step();

        // R6 R7 R9 R10: dedicated I/O bus mode
        do_reset(1'b1);
        arb_n = 1'b1;
        status = 3'b001;
        step();
        check("R6 io read immediate", outs(), expect_vec(1'b1, 1, 1));
        step();
        check("R7 io read ignores arb", outs(), expect_vec(1'b1, 1, 2));
        status = 3'b111;
        step();
        status = 3'b010;
        step();
        check("R6 io write advanced", outs(), expect_vec(1'b1, 2, 1));
        step();
        check("R10 io write full", outs(), expect_vec(1'b1, 2, 2));
        status = 3'b111;
        step();
        status = 3'b110;
        step();
        check("R6 memory still waits", {mrd, mwr, mwa, ird, iwr, iwa, ack, dual}, 8'b11111111);
        status = 3'b111;
        step();

        // R4: code change mid-cycle ignored
        do_reset(1'b0);
        arb_n = 1'b0;
        step(); step(); step();
        status = 3'b101;
        step(); step();
        status = 3'b110;
        step();
        check("R4 code held", outs(), expect_vec(1'b0, 5, 2));
        status = 3'b111;
        step();
        check("R4 ends on passive", outs(), expect_vec(1'b0, 5, 0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule